// File: doc/BRIEF.md
# UART Automatic Power-Down Controller

This block decides when the transmit half and the receive half of a serial port may stop their clocks. It watches the transmit holding buffer, the transmit shift register, the receive FIFO level and the receiver's start-bit hunt state. It raises a separate power-down flag for each direction, and external clock-enable logic uses those flags. The two directions sleep and wake on their own terms. The transmitter wakes when the host writes its buffer. The receiver wakes when the serial input line changes level.

Ring-indicator change detection keeps running whatever the power-down state. A level change on the ring-indicator input latches a modem-status interrupt request. The request stays set until the host reads the modem status register. The serial input and ring-indicator pins are asynchronous, so each passes through a two-flop synchronizer. An edge is then found by comparing the synchronized level with its value one cycle earlier. After a receive wake-up, the receiver is held awake for a programmable number of cycles, which gives the start-bit hunter a clock to run on.

Top module: `uart_autopd`

## Requirements
- R1: After reset, `txPowerDown`, `rxPowerDown` and `riChangeIrq` are all 0. The synchronizers reset to the line-idle levels: 1 for `rxdPin` and 0 for `riPin`.
- R2: `cfgReg[4]` enables transmit auto power-down. When it is 1, `txBufWrite` is 0, and both `txHoldEmpty` and `txShiftEmpty` are 1 at a clock edge, `txPowerDown` is 1 after that edge. If either empty input is 0, the flag does not rise.
- R3: A `txBufWrite` pulse clears `txPowerDown` at the next edge. A write in the same cycle as the entry condition wins, so the transmitter stays awake. While no write arrives, the flag stays 1 even if the empty inputs fall.
- R4: `cfgReg[5]` enables receive auto power-down. `rxPowerDown` rises at an edge when all of the following hold: the enable is 1, `rxFifoLevel` is 0, `rxHuntIdle` is 1, no wake-hold window is running and no RXD edge is detected. Once it is 1, it stays 1 until a wake or a disable.
- R5: Any change of `rxdPin`, rising or falling, clears `rxPowerDown` at the third rising clock edge after the change.
- R6: After a detected RXD edge, receive power-down entry is blocked for WAKE_HOLD further edges. With the entry condition held true, `rxPowerDown` rises again at the (WAKE_HOLD+1)-th edge after the wake edge.
- R7: Clearing a direction's enable bit forces that direction's flag to 0 at the next edge.
- R8: Any change of `riPin` sets `riChangeIrq` at the third edge after the change, whether or not either direction is powered down. A ring-indicator change alters neither power-down flag.
- R9: `riChangeIrq` holds until `msrRead` is sampled high, and it is 0 after that edge. If a new ring-indicator edge is detected in the same cycle as the read, the flag stays 1.
- R10: The directions are independent. A transmit write leaves `rxPowerDown` unchanged, and an RXD change leaves `txPowerDown` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgReg | input | 8 | Configuration register image; bit 4 enables transmit auto power-down, bit 5 enables receive auto power-down |
| txHoldEmpty | input | 1 | Transmit holding buffer is empty |
| txShiftEmpty | input | 1 | Transmit shift register is empty |
| txBufWrite | input | 1 | Host write strobe to the transmit buffer |
| rxFifoLevel | input | LEVEL_W | Number of entries in the receive FIFO |
| rxHuntIdle | input | 1 | Receiver is idle, hunting for a start bit |
| rxdPin | input | 1 | Asynchronous serial input line |
| riPin | input | 1 | Asynchronous ring-indicator input |
| msrRead | input | 1 | Host read strobe of the modem status register |
| txPowerDown | output | 1 | Transmitter may be clock-gated |
| rxPowerDown | output | 1 | Receiver may be clock-gated |
| riChangeIrq | output | 1 | Latched ring-indicator change interrupt request |

## Verification
The bench sweeps every combination of transmit enable, both empty flags and the write strobe, starting from an awake state and from an asleep state. A design that let the entry condition beat a simultaneous write, or that dropped out of sleep when the buffer status moved, would disagree with the arithmetic model. The receive side is swept across FIFO levels of zero, one and full, against the idle-hunt and enable inputs. The RXD wake path is timed to the exact edge for both polarities, so a missing synchronizer stage or a detector that sees only one polarity shows up as an off-by-one or a missed wake. The hold window is measured edge by edge, and the ring-indicator latch is checked against a read that coincides with a new edge, which catches a clear that overrides the set.

// File: rtl/uapd_pkg.sv
package uapd_pkg;
  localparam int TX_EN_BIT = 4;
  localparam int RX_EN_BIT = 5;

  // events reported by the datapath to the control
  typedef struct packed {
    logic rxEdge;
    logic riEdge;
    logic holdBusy;
  } evtBundle_t;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic riSet;
    logic riClr;
    logic holdLoad;
  } ctlStrobes_t;
endpackage

// File: rtl/uapd_edge.sv
module uapd_edge #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pinIn,
  output logic edgeSeen
);
  logic [STAGES-1:0] pipe;
  logic prevLvl;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= RESET_VAL;
        else        pipe <= pinIn;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RESET_VAL}};
        else        pipe <= {pipe[STAGES-2:0], pinIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevLvl <= RESET_VAL;
    else        prevLvl <= pipe[STAGES-1];
  end

  assign edgeSeen = pipe[STAGES-1] ^ prevLvl;

  // an edge means the registered level flips on the next cycle (R5, R8)
  p_edge_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edgeSeen |=> (prevLvl != $past(prevLvl)));
endmodule

// File: rtl/uapd_datapath.sv
module uapd_datapath
  import uapd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_HOLD   = 4,
  localparam int HOLD_W     = $clog2(WAKE_HOLD + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxdPin,
  input  logic        riPin,
  input  ctlStrobes_t strb,
  output evtBundle_t  evt,
  output logic        riChangeIrq
);
  logic rxEdge, riEdge;
  logic [HOLD_W-1:0] holdCnt;

  uapd_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_rxdEdge (
    .clk(clk), .rst_n(rst_n), .pinIn(rxdPin), .edgeSeen(rxEdge));

  uapd_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_riEdge (
    .clk(clk), .rst_n(rst_n), .pinIn(riPin), .edgeSeen(riEdge));

  // wake-hold window counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                holdCnt <= '0;
    else if (strb.holdLoad)    holdCnt <= HOLD_W'(WAKE_HOLD);
    else if (holdCnt != '0)    holdCnt <= holdCnt - 1'b1;
  end

  // ring-indicator change latch: set beats clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           riChangeIrq <= 1'b0;
    else if (strb.riSet)  riChangeIrq <= 1'b1;
    else if (strb.riClr)  riChangeIrq <= 1'b0;
  end

  always_comb begin
    evt.rxEdge   = rxEdge;
    evt.riEdge   = riEdge;
    evt.holdBusy = (holdCnt != '0);
  end

  p_ri_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.riSet |=> riChangeIrq);
  p_ri_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (riChangeIrq && !strb.riClr) |=> riChangeIrq);
  p_hold_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.holdLoad |=> evt.holdBusy);
endmodule

// File: rtl/uapd_ctrl.sv
module uapd_ctrl
  import uapd_pkg::*;
#(
  parameter int LEVEL_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         cfgReg,
  input  logic               txHoldEmpty,
  input  logic               txShiftEmpty,
  input  logic               txBufWrite,
  input  logic [LEVEL_W-1:0] rxFifoLevel,
  input  logic               rxHuntIdle,
  input  logic               msrRead,
  input  evtBundle_t         evt,
  output ctlStrobes_t        strb,
  output logic               txPowerDown,
  output logic               rxPowerDown
);
  logic txEn, rxEn, txEnter, rxEnter, rxFifoEmpty;

  assign txEn        = cfgReg[TX_EN_BIT];
  assign rxEn        = cfgReg[RX_EN_BIT];
  assign rxFifoEmpty = (rxFifoLevel == '0);
  assign txEnter     = txHoldEmpty && txShiftEmpty;
  assign rxEnter     = rxFifoEmpty && rxHuntIdle && !evt.holdBusy;

  always_comb begin
    strb.riSet    = evt.riEdge;
    strb.riClr    = msrRead && !evt.riEdge;
    strb.holdLoad = evt.rxEdge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       txPowerDown <= 1'b0;
    else if (!txEn || txBufWrite)     txPowerDown <= 1'b0;
    else if (txEnter)                 txPowerDown <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rxPowerDown <= 1'b0;
    else if (!rxEn || evt.rxEdge)     rxPowerDown <= 1'b0;
    else if (rxEnter)                 rxPowerDown <= 1'b1;
  end

  p_tx_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (txEn && txHoldEmpty && txShiftEmpty && !txBufWrite) |=> txPowerDown);
  p_tx_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txBufWrite |=> !txPowerDown);
  p_rx_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxPowerDown) |-> $past(rxFifoEmpty && rxHuntIdle && rxEn));
  p_rx_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rxEdge |=> !rxPowerDown);
  p_tx_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !txEn |=> !txPowerDown);
  p_rx_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEn |=> !rxPowerDown);
endmodule

// File: rtl/uart_autopd.sv
module uart_autopd
  import uapd_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_HOLD   = 4,
  localparam int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         cfgReg,
  input  logic               txHoldEmpty,
  input  logic               txShiftEmpty,
  input  logic               txBufWrite,
  input  logic [LEVEL_W-1:0] rxFifoLevel,
  input  logic               rxHuntIdle,
  input  logic               rxdPin,
  input  logic               riPin,
  input  logic               msrRead,
  output logic               txPowerDown,
  output logic               rxPowerDown,
  output logic               riChangeIrq
);
  evtBundle_t  evt;
  ctlStrobes_t strb;

  uapd_datapath #(.SYNC_STAGES(SYNC_STAGES), .WAKE_HOLD(WAKE_HOLD)) i_dp (
    .clk(clk), .rst_n(rst_n), .rxdPin(rxdPin), .riPin(riPin),
    .strb(strb), .evt(evt), .riChangeIrq(riChangeIrq));

  uapd_ctrl #(.LEVEL_W(LEVEL_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgReg(cfgReg),
    .txHoldEmpty(txHoldEmpty), .txShiftEmpty(txShiftEmpty),
    .txBufWrite(txBufWrite), .rxFifoLevel(rxFifoLevel),
    .rxHuntIdle(rxHuntIdle), .msrRead(msrRead), .evt(evt), .strb(strb),
    .txPowerDown(txPowerDown), .rxPowerDown(rxPowerDown));

  // a ring-indicator change never wakes a sleeping direction (R8)
  p_ri_no_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.riEdge && !evt.rxEdge && rxPowerDown && cfgReg[RX_EN_BIT]) |=> rxPowerDown);
  // a transmit write leaves receive sleep alone (R10)
  p_indep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (txBufWrite && rxPowerDown && cfgReg[RX_EN_BIT] && !evt.rxEdge) |=> rxPowerDown);
endmodule

// File: tb/test_uart_autopd.sv
module test_uart_autopd;
  localparam int FIFO_DEPTH = 16;
  localparam int HOLD       = 3;
  localparam int LEVEL_W    = $clog2(FIFO_DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfgReg = 8'h00;
  logic txHoldEmpty = 1'b0, txShiftEmpty = 1'b0, txBufWrite = 1'b0;
  logic [LEVEL_W-1:0] rxFifoLevel = '0;
  logic rxHuntIdle = 1'b0, rxdPin = 1'b1, riPin = 1'b0, msrRead = 1'b0;
  logic txPowerDown, rxPowerDown, riChangeIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_autopd #(.FIFO_DEPTH(FIFO_DEPTH), .SYNC_STAGES(2), .WAKE_HOLD(HOLD)) i_uart_autopd (
    .clk(clk), .rst_n(rst_n), .cfgReg(cfgReg),
    .txHoldEmpty(txHoldEmpty), .txShiftEmpty(txShiftEmpty), .txBufWrite(txBufWrite),
    .rxFifoLevel(rxFifoLevel), .rxHuntIdle(rxHuntIdle), .rxdPin(rxdPin),
    .riPin(riPin), .msrRead(msrRead), .txPowerDown(txPowerDown),
    .rxPowerDown(rxPowerDown), .riChangeIrq(riChangeIrq));

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic expTx, expRx;
    // R1 reset state
    step(3);
    check("R1 tx", txPowerDown, 1'b0);
    check("R1 rx", rxPowerDown, 1'b0);
    check("R1 ri", riChangeIrq, 1'b0);
    rst_n = 1'b1;
    step(2);

    // R2/R3/R7 transmit sweep from awake and asleep
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 16; v++) begin
        txBufWrite = 1'b0;
        cfgReg[4] = s[0];
        txHoldEmpty = s[0];
        txShiftEmpty = s[0];
        step(1);
        check("R2 tx setup", txPowerDown, s[0]);
        cfgReg[4]    = v[3];
        txHoldEmpty  = v[2];
        txShiftEmpty = v[1];
        txBufWrite   = v[0];
        step(1);
        expTx = v[3] & ~v[0] & (s[0] | (v[2] & v[1]));
        check(v[0] ? "R3 tx write" : (v[3] ? "R2 tx entry" : "R7 tx disable"),
              txPowerDown, expTx);
      end
    end
    txBufWrite = 1'b0;
    cfgReg[4] = 1'b0;
    step(1);

    // R4/R7 receive sweep over levels 0, 1, full
    for (int s = 0; s < 2; s++) begin
      for (int li = 0; li < 3; li++) begin
        for (int v = 0; v < 4; v++) begin
          cfgReg[5] = s[0];
          rxFifoLevel = '0;
          rxHuntIdle = s[0];
          step(1);
          check("R4 rx setup", rxPowerDown, s[0]);
          rxFifoLevel = (li == 0) ? '0 : (li == 1) ? LEVEL_W'(1) : LEVEL_W'(FIFO_DEPTH);
          cfgReg[5]  = v[1];
          rxHuntIdle = v[0];
          step(1);
          expRx = v[1] & (s[0] | ((li == 0) & v[0]));
          check(v[1] ? "R4 rx entry" : "R7 rx disable", rxPowerDown, expRx);
        end
      end
    end

    // R5/R6 wake on falling then rising RXD, with hold window
    cfgReg = 8'h30;
    rxFifoLevel = '0;
    rxHuntIdle = 1'b1;
    txHoldEmpty = 1'b1;
    txShiftEmpty = 1'b1;
    step(2);
    check("R4 asleep", rxPowerDown, 1'b1);
    check("R2 asleep", txPowerDown, 1'b1);
    for (int p = 0; p < 2; p++) begin
      rxdPin = ~rxdPin;
      step(2);
      check("R5 before wake", rxPowerDown, 1'b1);
      step(1);
      check("R5 wake", rxPowerDown, 1'b0);
      check("R10 tx untouched by rxd", txPowerDown, 1'b1);
      step(HOLD);
      check("R6 held awake", rxPowerDown, 1'b0);
      step(1);
      check("R6 re-entry", rxPowerDown, 1'b1);
    end

    // R10 transmit write leaves receiver asleep
    txBufWrite = 1'b1;
    step(1);
    txBufWrite = 1'b0;
    txHoldEmpty = 1'b0;
    check("R3 tx woke", txPowerDown, 1'b0);
    check("R10 rx untouched by write", rxPowerDown, 1'b1);
    step(1);
    check("R3 stays awake", txPowerDown, 1'b0);
    txHoldEmpty = 1'b1;
    step(1);

    // R8 ring indicator while both asleep, both polarities
    for (int p = 0; p < 2; p++) begin
      riPin = ~riPin;
      step(2);
      check("R8 not yet", riChangeIrq, 1'b0);
      step(1);
      check("R8 set", riChangeIrq, 1'b1);
      check("R8 tx sleep kept", txPowerDown, 1'b1);
      check("R8 rx sleep kept", rxPowerDown, 1'b1);
      step(2);
      check("R9 sticky", riChangeIrq, 1'b1);
      msrRead = 1'b1;
      step(1);
      msrRead = 1'b0;
      check("R9 cleared", riChangeIrq, 1'b0);
    end

    // R9 read coinciding with a new edge keeps the flag
    riPin = ~riPin;
    step(3);
    check("R9 set again", riChangeIrq, 1'b1);
    riPin = ~riPin;
    step(2);
    msrRead = 1'b1;
    step(1);
    msrRead = 1'b0;
    check("R9 set beats read", riChangeIrq, 1'b1);
    msrRead = 1'b1;
    step(1);
    msrRead = 1'b0;
    check("R9 later read clears", riChangeIrq, 1'b0);

    finished = 1'b1;
    summary();
  end
endmodule